// File: doc/BRIEF.md
# Trigger-Gated Dual-Clock Capture Buffer

This block takes a continuous stream of two-channel samples, one pair per clock of a fast sample clock. It keeps only a fixed-length window of sample pairs that an external trigger selects. Event triggers are rare compared with the sample rate, so almost every sample is thrown away. The trigger's timing is set upstream so that the sample of interest falls near the middle of the stored window.

The stored pairs cross into an unrelated read clock through a buffer whose pointers are Gray-coded. A downstream consumer drains that buffer with a valid/ready handshake, and the final word of each window carries a marker.

In the write clock domain the block raises a pulse when a window ends. It also keeps a sticky overflow flag and a saturating count of triggers it ignored. The window length is a power of two chosen at each trigger. When the buffer runs out of space in the middle of a window, the rest of that window is dropped, and the window still runs to its full length.

Top module: `trig_capture_buf`

## Requirements
- R1: No sample is stored while no window is open. With no trigger, `rd_valid` stays low.
- R2: `trig_in` passes through a two-flop synchronizer and a rising-edge detector. If `trig_in` is first seen high at `wr_clk` edge k, the first sample pair stored is the one present at edge k+3.
- R3: A window stores 2^`cfg_win_log2` consecutive sample pairs, in order. The length is taken when the trigger is accepted, and values above `MAX_WIN_LOG2` are limited to `MAX_WIN_LOG2`. Each word carries channel B in `rd_data[31:16]` and channel A in `rd_data[15:0]`.
- R4: `rd_last` is high with the word stored in the final slot of a window and low with every other word.
- R5: `win_done` is a one-cycle pulse. It is high during the `wr_clk` cycle that follows the edge storing the final slot of a window.
- R6: A trigger rising edge seen while a window is open is ignored, up to and including the window's final slot. Each such edge adds one to `miss_cnt`, which stops at its maximum value.
- R7: Once the buffer is full during a window, every remaining sample of that window is dropped and `ovf_flag` goes high. The flag stays high until reset. The window still ends after its full count. The words stored before the overflow arrive in order, and none of them carries `rd_last`.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_data` and `rd_last` hold their values. Each stored word is delivered exactly once.
- R9: After reset, `rd_valid`, `win_done`, `ovf_flag` and `miss_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sample clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| trig_in | input | 1 | Asynchronous event trigger |
| cfg_win_log2 | input | 4 | log2 of the window length |
| samp_a | input | 16 | Channel A sample |
| samp_b | input | 16 | Channel B sample |
| win_done | output | 1 | Pulse when a window ends |
| ovf_flag | output | 1 | Sticky overflow flag |
| miss_cnt | output | 8 | Count of ignored triggers, saturating |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_valid | output | 1 | A word is available |
| rd_ready | input | 1 | Consumer accepts the word |
| rd_data | output | 32 | {channel B, channel A} |
| rd_last | output | 1 | Final word of a window |

## Verification
The case that needs the most care is a trigger edge whose detection lands on the same write edge as a window's final slot. That edge both ends the window and sees a rising trigger. The bench places a second trigger so that its detection coincides with the final slot, and expects one window, one extra miss count and a single end pulse. It then moves the second trigger one cycle later and expects two back-to-back windows with no miss. A second collision is also driven: a stalled reader lets the buffer fill in the middle of a window, and the bench expects exactly the buffer depth of words, no last marker, and the window still closing on time.

// File: rtl/tcb_pkg.sv
`timescale 1ns / 1ps
// Shared types for the trigger-gated capture buffer.
package tcb_pkg;
    // State of the window controller in the write domain.
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,   // no window open
        CAP_STORE = 2'd1,   // window open, samples stored
        CAP_DROP  = 2'd2    // window open after an overflow, samples dropped
    } cap_state_e;
endpackage

// File: rtl/tcb_sync_bits.sv
`timescale 1ns / 1ps
// Multi-stage flop synchronizer for a vector.
// Assumes: each bit is independently safe to sample. This holds for a single
// level signal or for a Gray-coded value that changes one bit at a time.
module tcb_sync_bits #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    // Shift the asynchronous value through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/tcb_trig_ctrl.sv
`timescale 1ns / 1ps
// Write-domain window controller. It synchronizes the trigger and detects its
// rising edge, opens a window of 2^log2 slots, and issues write requests.
// It also drops samples after an overflow, pulses at the end of a window and
// counts ignored triggers.
// Assumes: the window length input is stable around the accepting edge.
module tcb_trig_ctrl
    import tcb_pkg::*;
#(
    parameter int LOG2_W      = 4,
    parameter int MAX_LOG2    = 10,
    parameter int MISS_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_async,
    input  logic [LOG2_W-1:0] cfg_log2,
    input  logic              fifo_full,
    output logic              wr_en,
    output logic              wr_last,
    output logic              win_done,
    output logic              ovf_flag,
    output logic [MISS_W-1:0] miss_cnt
);
    localparam int CNT_W = MAX_LOG2 + 1;

    logic              trig_s, trig_d, trig_rise;
    cap_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q, last_idx_q;
    logic              in_slot, final_slot;
    logic              done_q, ovf_q;
    logic [MISS_W-1:0] miss_q;

    // Returns the index of the final slot, with the length limited to MAX_LOG2.
    function automatic logic [CNT_W-1:0] final_index(input logic [LOG2_W-1:0] l2);
        logic [CNT_W-1:0] one;
        int               sh;
        one = CNT_W'(1);
        sh  = (int'(l2) > MAX_LOG2) ? MAX_LOG2 : int'(l2);
        return (one << sh) - one;
    endfunction

    tcb_sync_bits #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_trig_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (trig_async),
        .q     (trig_s)
    );

    // Hold the previous synchronized trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_d <= 1'b0;
        else        trig_d <= trig_s;
    end

    assign trig_rise  = trig_s & ~trig_d;
    assign in_slot    = (state_q != CAP_IDLE);
    assign final_slot = in_slot && (cnt_q == last_idx_q);
    assign wr_en      = (state_q == CAP_STORE) && !fifo_full;
    assign wr_last    = final_slot;

    // Window sequencing: open on an accepted edge, count slots, close after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= CAP_IDLE;
            cnt_q      <= '0;
            last_idx_q <= '0;
        end else begin
            case (state_q)
                CAP_IDLE: begin
                    if (trig_rise) begin
                        state_q    <= CAP_STORE;
                        cnt_q      <= '0;
                        last_idx_q <= final_index(cfg_log2);
                    end
                end
                CAP_STORE, CAP_DROP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (final_slot)
                        state_q <= CAP_IDLE;
                    else if (state_q == CAP_STORE && fifo_full)
                        state_q <= CAP_DROP;
                end
                default: state_q <= CAP_IDLE;
            endcase
        end
    end

    // Pulse after the final slot, and latch any sample that was dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            done_q <= final_slot;
            if (state_q == CAP_STORE && fifo_full) ovf_q <= 1'b1;
        end
    end

    // Count trigger edges that arrive while a window is open, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            miss_q <= '0;
        else if (trig_rise && in_slot && miss_q != {MISS_W{1'b1}})
            miss_q <= miss_q + 1'b1;
    end

    assign win_done = done_q;
    assign ovf_flag = ovf_q;
    assign miss_cnt = miss_q;
endmodule

// File: rtl/tcb_gray_fifo.sv
`timescale 1ns / 1ps
// Dual-clock FIFO with Gray-coded pointers and a first-word-fall-through read
// port. Full and empty are registered and derived from the other side's
// synchronized pointer, which can only lag. Full therefore errs toward full,
// and empty errs toward empty.
// Assumes: ADDR_W >= 2, and both resets are held together for a few cycles of each clock.
module tcb_gray_fifo #(
    parameter int DATA_W      = 33,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PTR_W = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];

    logic [PTR_W-1:0] wbin_q, wgray_q, wbin_nx, wgray_nx, rgray_in_w;
    logic [PTR_W-1:0] rbin_q, rgray_q, rbin_nx, rgray_nx, wgray_in_r;
    logic             full_q, empty_q, push, pop;

    // Converts a binary pointer to its reflected Gray code.
    function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    assign push     = wr_en && !full_q;
    assign pop      = rd_ready && !empty_q;
    assign wbin_nx  = wbin_q + {{(PTR_W-1){1'b0}}, push};
    assign wgray_nx = to_gray(wbin_nx);
    assign rbin_nx  = rbin_q + {{(PTR_W-1){1'b0}}, pop};
    assign rgray_nx = to_gray(rbin_nx);

    tcb_sync_bits #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_rptr_sync (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray_q),
        .q     (rgray_in_w)
    );

    tcb_sync_bits #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wptr_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray_q),
        .q     (wgray_in_r)
    );

    // Store the incoming word at the write address.
    always_ff @(posedge wr_clk) begin
        if (push) mem[wbin_q[ADDR_W-1:0]] <= wr_data;
    end

    // Advance the write pointer and compare it with the lagging read pointer to decide full.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            full_q  <= 1'b0;
        end else begin
            wbin_q  <= wbin_nx;
            wgray_q <= wgray_nx;
            full_q  <= (wgray_nx == {~rgray_in_w[PTR_W-1:PTR_W-2], rgray_in_w[PTR_W-3:0]});
        end
    end

    // Advance the read pointer and compare it with the lagging write pointer to decide empty.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            empty_q <= 1'b1;
        end else begin
            rbin_q  <= rbin_nx;
            rgray_q <= rgray_nx;
            empty_q <= (rgray_nx == wgray_in_r);
        end
    end

    assign wr_full  = full_q;
    assign rd_valid = !empty_q;
    assign rd_data  = mem[rbin_q[ADDR_W-1:0]];
endmodule

// File: rtl/trig_capture_buf.sv
`timescale 1ns / 1ps
// Top of the trigger-gated dual-clock capture buffer. It joins the
// write-domain window controller to the Gray-pointer FIFO. Each stored word is
// {last, channel B, channel A}.
// Assumes: wr_clk and rd_clk are unrelated, and trig_in is asynchronous.
module trig_capture_buf #(
    parameter int SAMPLE_W     = 16,
    parameter int LOG2_W       = 4,
    parameter int MAX_WIN_LOG2 = 10,
    parameter int FIFO_ADDR_W  = 8,
    parameter int MISS_W       = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                  wr_clk,
    input  logic                  wr_rst_n,
    input  logic                  trig_in,
    input  logic [LOG2_W-1:0]     cfg_win_log2,
    input  logic [SAMPLE_W-1:0]   samp_a,
    input  logic [SAMPLE_W-1:0]   samp_b,
    output logic                  win_done,
    output logic                  ovf_flag,
    output logic [MISS_W-1:0]     miss_cnt,
    input  logic                  rd_clk,
    input  logic                  rd_rst_n,
    output logic                  rd_valid,
    input  logic                  rd_ready,
    output logic [2*SAMPLE_W-1:0] rd_data,
    output logic                  rd_last
);
    localparam int WORD_W = 2 * SAMPLE_W + 1;

    logic              wr_en, wr_last, fifo_full;
    logic [WORD_W-1:0] fifo_out;

    tcb_trig_ctrl #(
        .LOG2_W      (LOG2_W),
        .MAX_LOG2    (MAX_WIN_LOG2),
        .MISS_W      (MISS_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ctrl (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .trig_async (trig_in),
        .cfg_log2   (cfg_win_log2),
        .fifo_full  (fifo_full),
        .wr_en      (wr_en),
        .wr_last    (wr_last),
        .win_done   (win_done),
        .ovf_flag   (ovf_flag),
        .miss_cnt   (miss_cnt)
    );

    tcb_gray_fifo #(
        .DATA_W      (WORD_W),
        .ADDR_W      (FIFO_ADDR_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_fifo (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_data  ({wr_last, samp_b, samp_a}),
        .wr_full  (fifo_full),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_data  (fifo_out)
    );

    assign rd_data = fifo_out[2*SAMPLE_W-1:0];
    assign rd_last = fifo_out[WORD_W-1];
endmodule

// File: rtl/trig_capture_buf_chk.sv
`timescale 1ns / 1ps
// Protocol checker for trig_capture_buf. It watches the top's ports in both
// clock domains and is bound to every instance of the top.
module trig_capture_buf_chk #(
    parameter int MISS_W = 8,
    parameter int DATA_W = 32
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              win_done,
    input logic              ovf_flag,
    input logic [MISS_W-1:0] miss_cnt,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_last
);
    // R5: the end-of-window pulse lasts a single cycle.
    assert_done_pulse_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        win_done |=> !win_done);

    // R7: once raised, the overflow flag stays up until reset.
    assert_ovf_sticky_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        ovf_flag |=> ovf_flag);

    // R6: the ignored-trigger count only ever steps up by one.
    assert_miss_step_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !$stable(miss_cnt) |-> (miss_cnt == $past(miss_cnt) + 1'b1));

    // R8: a stalled word stays offered and unchanged.
    assert_rd_hold_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));
endmodule

bind trig_capture_buf trig_capture_buf_chk #(.MISS_W(MISS_W), .DATA_W(2*SAMPLE_W)) i_chk (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .win_done (win_done),
    .ovf_flag (ovf_flag),
    .miss_cnt (miss_cnt),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .rd_last  (rd_last)
);

// File: tb/test_trig_capture_buf.sv
`timescale 1ns / 1ps
module test_trig_capture_buf;
    localparam int MAXL  = 10;
    localparam int DEPTH = 256;

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic [3:0]  cfg_win_log2 = 4'd0;
    logic [15:0] samp_a = 16'd0, samp_b = 16'hA5A5, scnt = 16'd0;
    logic        win_done, ovf_flag, rd_valid, rd_last;
    logic        rd_ready = 1'b0;
    logic [7:0]  miss_cnt;
    logic [31:0] rd_data;

    int checks = 0, errors = 0, done_cnt = 0, rdy_pct = 0;
    logic [32:0] got[$];
    logic [32:0] exp_q[$];

    trig_capture_buf i_trig_capture_buf (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .trig_in(trig_in),
        .cfg_win_log2(cfg_win_log2), .samp_a(samp_a), .samp_b(samp_b),
        .win_done(win_done), .ovf_flag(ovf_flag), .miss_cnt(miss_cnt),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last)
    );

    always #2   wr_clk = ~wr_clk;   // 250 MHz sample clock
    always #2.5 rd_clk = ~rd_clk;   // unrelated read clock

    // Sample source: a counter on A, its scrambled copy on B.
    always @(negedge wr_clk) begin
        scnt   = scnt + 16'd1;
        samp_a = scnt;
        samp_b = scnt ^ 16'hA5A5;
    end

    // Count end-of-window pulses.
    always @(negedge wr_clk) if (wr_rst_n && win_done) done_cnt++;

    // Consumer: random ready; an accepted word is recorded before the edge that takes it.
    always @(negedge rd_clk) begin
        bit r;
        r = ($urandom_range(99) < rdy_pct);
        rd_ready = r;
        if (rd_rst_n && rd_valid && r) got.push_back({rd_last, rd_data});
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int win_len(input int l2);
        return 1 << ((l2 > MAXL) ? MAXL : l2);
    endfunction

    // Expected words of a window: n stored words starting at sample 'first'.
    task automatic push_win(input logic [15:0] first, input int len, input int n);
        for (int i = 0; i < n; i++) begin
            logic [15:0] a;
            a = first + 16'(i);
            exp_q.push_back({(i == len - 1), a ^ 16'hA5A5, a});
        end
    endtask

    // Raise the trigger just after an edge (P0), return the sample seen then; ends at P3+1.
    task automatic fire(output logic [15:0] v);
        @(posedge wr_clk); #1;
        trig_in = 1'b1;
        v = samp_a;
        repeat (3) @(posedge wr_clk);
        #1 trig_in = 1'b0;
    endtask

    task automatic second_trig(output logic [15:0] v);
        #1 trig_in = 1'b1;
        v = samp_a;
        repeat (3) @(posedge wr_clk);
        #1 trig_in = 1'b0;
    endtask

    // Wait until the consumer has the expected number of words, then compare.
    task automatic drain_compare(input string req);
        int bad, first_bad;
        for (int t = 0; t < 30000 && got.size() < exp_q.size(); t++) @(posedge rd_clk);
        repeat (60) @(posedge rd_clk);
        check(got.size() == exp_q.size(), req, "word count", got.size(), exp_q.size());
        bad = 0; first_bad = -1;
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            if (got[i] !== exp_q[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        if (first_bad >= 0)
            check(1'b0, req, $sformatf("word %0d {last,B,A}", first_bad),
                  longint'(got[first_bad]), longint'(exp_q[first_bad]));
        else
            check(1'b1, req, "words", 0, 0);
        got.delete();
        exp_q.delete();
    endtask

    // One window with edge-exact end-pulse timing (R2, R3, R4, R5).
    task automatic run_win(input int l2, input int pct, input string req);
        logic [15:0] v;
        int L, d0;
        L = win_len(l2);
        cfg_win_log2 = 4'(l2);
        rdy_pct = pct;
        d0 = done_cnt;
        fire(v);
        repeat (L - 1) @(posedge wr_clk);
        @(negedge wr_clk);
        check(win_done == 1'b0, "R5", "done before final slot", win_done, 0);
        @(posedge wr_clk);
        @(negedge wr_clk);
        check(win_done == 1'b1, "R5", "done after final slot", win_done, 1);
        push_win(v + 16'd4, L, L);   // R2: first stored is the sample 3 edges after the first sync edge
        drain_compare(req);
        check(done_cnt == d0 + 1, "R5", "one pulse per window", done_cnt, d0 + 1);
    endtask

    initial begin
        logic [15:0] v, v2;
        int m0, d0;
        void'($urandom(32'd20240611));
        repeat (8) @(posedge wr_clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        @(negedge wr_clk);
        check(rd_valid == 0 && win_done == 0 && ovf_flag == 0 && miss_cnt == 0,
              "R9", "reset state", {rd_valid, win_done, ovf_flag, miss_cnt}, 0);

        // R1: no trigger, nothing stored
        rdy_pct = 100;
        repeat (300) @(posedge wr_clk);
        check(got.size() == 0 && rd_valid == 0, "R1", "idle words", got.size(), 0);

        // Random windows with random consumer back-pressure (R3, R4, R8)
        for (int k = 0; k < 6; k++)
            run_win($urandom_range(7, 0), $urandom_range(100, 20), "R3");

        // R3: oversized length request limited to MAX_WIN_LOG2
        run_win(15, 100, "R3");
        check(ovf_flag == 0, "R3", "no overflow with fast reader", ovf_flag, 0);

        // R6: trigger inside an open window is ignored and counted
        cfg_win_log2 = 4'd6; rdy_pct = 90;
        m0 = int'(miss_cnt); d0 = done_cnt;
        fire(v);
        repeat (10) @(posedge wr_clk);
        second_trig(v2);
        repeat (90) @(posedge wr_clk);
        check(int'(miss_cnt) == m0 + 1, "R6", "miss count", miss_cnt, m0 + 1);
        check(done_cnt == d0 + 1, "R6", "single window", done_cnt, d0 + 1);
        push_win(v + 16'd4, 64, 64);
        drain_compare("R6");

        // R6: second edge detected on the final slot is still ignored
        cfg_win_log2 = 4'd4;
        m0 = int'(miss_cnt); d0 = done_cnt;
        fire(v);
        repeat (16 - 3) @(posedge wr_clk);
        second_trig(v2);
        repeat (40) @(posedge wr_clk);
        check(int'(miss_cnt) == m0 + 1, "R6", "final-slot miss", miss_cnt, m0 + 1);
        check(done_cnt == d0 + 1, "R6", "final-slot single window", done_cnt, d0 + 1);
        push_win(v + 16'd4, 16, 16);
        drain_compare("R6");

        // R3: edge detected one cycle after the final slot opens a new window
        m0 = int'(miss_cnt); d0 = done_cnt;
        fire(v);
        repeat (16 - 2) @(posedge wr_clk);
        second_trig(v2);
        repeat (40) @(posedge wr_clk);
        check(int'(miss_cnt) == m0, "R3", "back-to-back no miss", miss_cnt, m0);
        check(done_cnt == d0 + 2, "R5", "back-to-back pulses", done_cnt, d0 + 2);
        push_win(v + 16'd4, 16, 16);
        push_win(v2 + 16'd4, 16, 16);
        drain_compare("R4");

        // R7: stalled reader, window larger than the buffer
        rdy_pct = 0; cfg_win_log2 = 4'd10; d0 = done_cnt;
        fire(v);
        repeat (1100) @(posedge wr_clk);
        check(ovf_flag == 1, "R7", "overflow flag", ovf_flag, 1);
        check(done_cnt == d0 + 1, "R7", "window ends after full count", done_cnt, d0 + 1);
        rdy_pct = 70;
        push_win(v + 16'd4, 1024, DEPTH);
        drain_compare("R7");

        // R7: flag stays set, and normal windows resume
        run_win(3, 80, "R4");
        check(ovf_flag == 1, "R7", "flag sticky", ovf_flag, 1);

        // R9: reset clears flags
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        repeat (6) @(posedge wr_clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        @(negedge wr_clk);
        check(ovf_flag == 0 && miss_cnt == 0 && rd_valid == 0, "R9", "reset clears",
              {ovf_flag, miss_cnt, rd_valid}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge wr_clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule